// File: doc/BRIEF.md
# I2C Slave Address Detector

This block handles the address phase of an I2C slave. It samples the open-drain SCL and SDA lines through a synchronizer and watches for a start condition. After a start it shifts in a seven-bit address and a direction bit. It then compares the address with an own address supplied on an input, and also with the general-call address.

On a match, the block pulls SDA low for the ninth clock as an acknowledge. When that clock falls, it pulses an interrupt, clears a pending flag and holds SCL low. SCL stays low until software gives a one-cycle release strobe. When the address does not match, the block stays off the bus until the next start or stop. Data bytes, master operation and arbitration are handled elsewhere.

Top module: `i2c_addr_watch`

## Requirements
- R1: Address reception begins only after a start condition, which is SDA falling while SCL is high. SCL clocks with no preceding start cause no acknowledge and no interrupt.
- R2: The eight bits sampled on the first eight rising SCL edges after a start are, in order, address bit 6 down to address bit 0 and then the direction bit. The direction bit of an acknowledged frame appears on `rw_o` (1 = read).
- R3: If the address equals `own_addr_i`, `sda_pull_o` goes high on the SCL falling edge that ends the eighth clock. It stays high through the ninth clock and drops on the falling edge that ends the ninth clock.
- R4: Address 0000000 with direction bit 0 is a general call. It is acknowledged and sets `gc_o`. Address 0000000 with direction bit 1 is acknowledged only if it equals the own address, and in that case `gc_o` stays 0.
- R5: On the falling edge that ends the ninth clock of an acknowledged frame, `irq_o` pulses high for one cycle and `pending_o` goes to 0.
- R6: While `pending_o` is 0, `scl_pull_o` holds SCL low, even when the master releases it.
- R7: A one-cycle `release_i` while `pending_o` is 0 sets `pending_o` to 1, which releases SCL.
- R8: On an address mismatch, SDA is not driven on the ninth clock and no interrupt is raised. Further clocks before the next start or stop are ignored.
- R9: A stop condition (SDA rising while SCL is high) returns the block to idle with both pull enables low. A start seen at any time, including in the middle of an address, restarts address reception.
- R10: After reset, `pending_o` is 1 and `scl_pull_o`, `sda_pull_o`, `irq_o`, `rw_o` and `gc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| own_addr_i | input | 7 | Own slave address |
| release_i | input | 1 | One-cycle strobe that releases the stretched SCL |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| irq_o | output | 1 | One-cycle interrupt pulse for an acknowledged address |
| pending_o | output | 1 | Pending flag; 0 while the block stretches SCL |
| rw_o | output | 1 | Direction bit of the last acknowledged frame |
| gc_o | output | 1 | The last acknowledged frame was a general call |

## Verification
The main stimulus is a sweep of every seven-bit address with both direction bits against a fixed own address. This separates own-address hits, general-call hits, the general-call address sent with a read bit, and plain misses, and it shows that the address is assembled in MSB-first order.

A second own address of zero separates an own match from a general call on the same zero address. Every miss is followed by a further byte of clocks, which shows that the block stays silent until a stop. Clocking an address with no start exercises the start gate. A start issued partway through an address checks that reception restarts.

// File: rtl/i2c_aw_pkg.sv
package i2c_aw_pkg;
  localparam int unsigned AW = 7;
  localparam int unsigned FW = AW + 1;
  localparam logic [AW-1:0] GC_ADDR = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } aw_state_e;

  typedef struct packed {
    logic own;
    logic gc;
  } aw_hit_t;

  // frame = {addr[AW-1:0], rw}
  function automatic aw_hit_t classify(input logic [FW-1:0] frame,
                                       input logic [AW-1:0] own);
    aw_hit_t h;
    h.own = (frame[FW-1:1] == own);
    h.gc  = (frame[FW-1:1] == GC_ADDR) && !frame[0];
    return h;
  endfunction
endpackage

// File: rtl/i2c_aw_sync.sv
module i2c_aw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= level;
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/i2c_aw_cond.sv
module i2c_aw_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_evt,
  output logic stop_evt
);
  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;
endmodule

// File: rtl/i2c_aw_fsm.sv
module i2c_aw_fsm
  import i2c_aw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic [AW-1:0] own_addr,
  input  logic          release_i,
  output logic          sda_pull_o,
  output logic          pending_o,
  output logic          irq_o,
  output logic          rw_o,
  output logic          gc_o
);
  localparam int unsigned CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW);

  aw_state_e      state;
  logic [CW-1:0]  cnt;
  logic [FW-1:0]  shreg;
  aw_hit_t        hit;
  logic           frame_done;
  logic           take_bit;

  assign hit        = classify(shreg, own_addr);
  assign frame_done = scl_fall && (cnt == LAST);
  assign take_bit   = scl_rise && (cnt != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      pending_o <= 1'b1;
      irq_o     <= 1'b0;
      rw_o      <= 1'b0;
      gc_o      <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (stop_evt) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        pending_o <= 1'b1;
      end else if (start_evt) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        pending_o <= 1'b1;
        rw_o      <= 1'b0;
        gc_o      <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (take_bit) begin
              shreg <= {shreg[FW-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (frame_done) begin
              if (hit.own || hit.gc) begin
                state <= ST_ACK;
                rw_o  <= shreg[0];
                gc_o  <= hit.gc;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state     <= ST_HOLD;
              pending_o <= 1'b0;
              irq_o     <= 1'b1;
            end
          end
          ST_HOLD: begin
            if (release_i) begin
              pending_o <= 1'b1;
              state     <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = (state == ST_ACK);

  assert_irq_clears_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !pending_o);
  assert_irq_with_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $fell(sda_pull_o));
  assert_ack_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));
  assert_stretch_only_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_o |-> (state == ST_HOLD));
  assert_release_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !pending_o && !stop_evt) |=> pending_o);
  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (pending_o && !sda_pull_o));
endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
  import i2c_aw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          release_i,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          irq_o,
  output logic          pending_o,
  output logic          rw_o,
  output logic          gc_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_evt, stop_evt;

  i2c_aw_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  i2c_aw_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  i2c_aw_cond u_cond (
    .scl_lvl(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_aw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .own_addr(own_addr_i), .release_i(release_i),
    .sda_pull_o(sda_pull_o), .pending_o(pending_o), .irq_o(irq_o),
    .rw_o(rw_o), .gc_o(gc_o)
  );

  assign scl_pull_o = ~pending_o;

  assert_no_start_and_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));
  assert_no_double_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_pull_o && scl_pull_o));
endmodule

// File: tb/test_i2c_addr_watch.sv
module test_i2c_addr_watch;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own = 7'h2A;
  logic rel = 1'b0;
  logic scl_pull, sda_pull, irq, pending, rw, gc;
  wire  scl_line = scl_m & ~scl_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, pull_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_watch i_i2c_addr_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .own_addr_i(own), .release_i(rel),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .irq_o(irq),
    .pending_o(pending), .rw_o(rw), .gc_o(gc)
  );

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (sda_pull) pull_cnt <= pull_cnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wt(2*H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic send_frame(input logic [6:0] a, input logic r);
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(r);
  endtask

  // ninth clock, hold phase and stop; expectations computed from R2-R9
  task automatic finish_frame(input logic [6:0] a, input logic r);
    int i0, p0;
    logic hit, gce;
    gce = (a == 7'd0) && !r;
    hit = (a == own) || gce;
    i0 = irq_cnt;
    check("R3 ack drive after 8th fall", int'(sda_pull), int'(hit));
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(2*H);
    check("R3 SDA line during 9th clock", int'(sda_line), int'(!hit));
    scl_m = 1'b0; wt(H);
    check("R3 ack released after 9th fall", int'(sda_pull), 0);
    check("R5 irq pulses once on match", irq_cnt - i0, int'(hit));
    check("R5 pending cleared on match", int'(pending), int'(!hit));
    if (hit) begin
      check("R2 direction bit", int'(rw), int'(r));
      check("R4 general-call flag", int'(gc), int'(gce));
      scl_m = 1'b1; wt(2*H);
      check("R6 SCL stretched", int'(scl_line), 0);
      rel = 1'b1; wt(1); rel = 1'b0; wt(H);
      check("R7 SCL released", int'(scl_line), 1);
      check("R7 pending set", int'(pending), 1);
    end else begin
      p0 = pull_cnt;
      i0 = irq_cnt;
      for (int k = 0; k < 9; k++) send_bit(1'b0);
      check("R8 ignored byte: no SDA drive", pull_cnt - p0, 0);
      check("R8 ignored byte: no irq", irq_cnt - i0, 0);
    end
    bus_stop();
    check("R9 idle after stop: SDA", int'(sda_pull), 0);
    check("R9 idle after stop: SCL", int'(scl_pull), 0);
  endtask

  initial begin
    int p0, i0;
    wt(3);
    check("R10 reset pending", int'(pending), 1);
    check("R10 reset scl pull", int'(scl_pull), 0);
    check("R10 reset sda pull", int'(sda_pull), 0);
    check("R10 reset irq", int'(irq), 0);
    check("R10 reset rw", int'(rw), 0);
    check("R10 reset gc", int'(gc), 0);
    rst_n = 1'b1; wt(4);

    // R1: clocks without a start
    p0 = pull_cnt; i0 = irq_cnt;
    scl_m = 1'b0; wt(H);
    send_frame(own, 1'b0);
    send_bit(1'b1);
    check("R1 no ack without start", pull_cnt - p0, 0);
    check("R1 no irq without start", irq_cnt - i0, 0);
    bus_stop();

    // main sweep: every address, both directions (R2, R3, R4, R5, R8)
    for (int a = 0; a < 128; a++) begin
      for (int r = 0; r < 2; r++) begin
        bus_start();
        send_frame(7'(a), 1'(r));
        finish_frame(7'(a), 1'(r));
      end
    end

    // R4: own address zero separates own match from general call
    own = 7'h00;
    bus_start(); send_frame(7'h00, 1'b1); finish_frame(7'h00, 1'b1);
    bus_start(); send_frame(7'h00, 1'b0); finish_frame(7'h00, 1'b0);
    bus_start(); send_frame(7'h01, 1'b0); finish_frame(7'h01, 1'b0);

    // R9: repeated start in mid-address restarts reception
    own = 7'h55;
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_frame(7'h55, 1'b1);
    finish_frame(7'h55, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule